// File: doc/BRIEF.md
# ATA Task-File I/O Window Decoder

This block sits on the card side of a 16-byte I/O window that holds an ATA task file. It takes a four-bit offset, two active-low card enables and active-low read and write strobes. For each access it decides whether the access is a full 16-bit transfer, a byte on the low lane (D7-D0) or a byte on the high lane (D15-D8). It then routes the access to a task-file register or to an internal sector buffer. The strobes are taken as already synchronous to `clk`.

The data port appears at several offsets. Each one has its own byte-order rule, and all of them share one even/odd byte pointer and one incrementing word address. Byte-wide transfers therefore walk through the buffer in order. A write to the command register clears that position and sends a one-cycle pulse to the command engine. Status, error and drive-address values come in from that engine on input pins.

The bus state machine has three states. ST_IDLE goes to ST_READ when a card enable and the read strobe are both low, and to ST_WRITE when a card enable and the write strobe are both low. The decode is latched on that transition. ST_READ returns to ST_IDLE when the read strobe rises, and ST_WRITE returns to ST_IDLE when the write strobe rises. That rising-strobe transition is the commit cycle: writes land in it and the buffer position moves in it.

Top module: `ata_tf_decoder`

## Requirements
- R1: After reset, both output enables and `cmd_strobe` are low, `features_o`, `dev_ctl_o` and `command_o` are 0, every writable task-file register reads 0, and the buffer position is word 0, even byte.
- R2: Byte reads return the following. Offsets 2, 3, 4, 5 and 6 return sector count, sector number, cylinder low, cylinder high and card/head. Offsets 1 and 0xD return `err_in`. Offsets 7 and 0xE return `status_in`. Offset 0xF returns `drv_addr_in`.
- R3: Byte writes store into sector count, sector number, cylinder low, cylinder high and card/head at offsets 2 to 6. Offsets 1 and 0xD write `features_o`, offset 7 writes `command_o` and offset 0xE writes `dev_ctl_o`. A write to offset 0xF changes no register.
- R4: An access with both card enables high is ignored. Both output enables stay low, `data_out` is 0, no register changes and the buffer position does not move.
- R5: With only `ce2_n` low, the access is a byte on D15-D8 to offset {A3..A1,1}. At offset 0 it reads `err_in` and writes `features_o`, and it never touches the buffer.
- R6: With only `ce1_n` low, a read drives D7-D0 only (`data_oe_lo`=1, `data_oe_hi`=0). With both enables low, a read drives both lanes. With only `ce2_n` low, a read drives only `data_oe_hi`.
- R7: With both enables low at offsets 0, 1, 8 or 9, the access is a 16-bit data transfer. A0 is ignored, and successive transfers read or write consecutive buffer words.
- R8: Low-lane byte accesses at offset 0 or 8 step through the buffer as even byte then odd byte. The word address advances after the second byte, and the position moves only when the strobe is released.
- R9: A byte access at offset 9 always takes the odd byte of the current word. Alternating 8 then 9 gives even then odd. Accessing 9 then 8 gives the odd byte and then the even byte of the same word.
- R10: A write to the command register (offset 7, or the high lane of a word write at offset 6) resets the buffer position to word 0, even byte. It also raises `cmd_strobe` for exactly one cycle.
- R11: A 16-bit access at a non-data offset pair reaches the even-offset register on D7-D0 and the odd-offset register on D15-D8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Window offset A3..A0 |
| ce1_n | input | 1 | Card enable for the low lane, active low |
| ce2_n | input | 1 | Card enable for the high lane, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| data_in | input | 16 | Write data from the host, both lanes |
| data_out | output | 16 | Read data to the host |
| data_oe_lo | output | 1 | Drive enable for D7-D0 |
| data_oe_hi | output | 1 | Drive enable for D15-D8 |
| err_in | input | 8 | Error value from the command engine |
| status_in | input | 8 | Status value from the command engine |
| drv_addr_in | input | 8 | Drive-address value from the command engine |
| features_o | output | 8 | Features register |
| dev_ctl_o | output | 8 | Device control register |
| command_o | output | 8 | Command register |
| cmd_strobe | output | 1 | One-cycle pulse after a command write |

## Verification
The register map is swept offset by offset with low-lane byte writes and reads, then with high-lane and 16-bit accesses. This separates lane steering from register selection. The buffer is filled with words whose two bytes differ arithmetically. Word, sequential-byte, 8-then-9 and 9-then-8 read orders are then replayed, so a wrong byte pick, a missed address step or a step taken on the wrong byte each give a distinct wrong value. Command writes in the middle of a word, and accesses with no card enable, show whether the position is cleared, or left alone, as required.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_BYTE_LO,
        ACC_BYTE_HI,
        ACC_WORD
    } acc_kind_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA_SEQ,
        SEL_DATA_ODD,
        SEL_DATA_WORD,
        SEL_ERR_FEAT,
        SEL_SEC_CNT,
        SEL_SEC_NUM,
        SEL_CYL_LO,
        SEL_CYL_HI,
        SEL_CARD_HEAD,
        SEL_STAT_CMD,
        SEL_ALT_CTL,
        SEL_DRV_RSV
    } tf_sel_e;

    typedef struct packed {
        acc_kind_e kind;
        tf_sel_e   lo;
        tf_sel_e   hi;
    } acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } bus_state_e;

    localparam int NUM_TF = 8;

    // Register selected by a byte access at a given offset
    function automatic tf_sel_e byte_sel(input logic [3:0] off);
        tf_sel_e s;
        case (off)
            4'h0, 4'h8: s = SEL_DATA_SEQ;
            4'h9:       s = SEL_DATA_ODD;
            4'h1, 4'hD: s = SEL_ERR_FEAT;
            4'h2:       s = SEL_SEC_CNT;
            4'h3:       s = SEL_SEC_NUM;
            4'h4:       s = SEL_CYL_LO;
            4'h5:       s = SEL_CYL_HI;
            4'h6:       s = SEL_CARD_HEAD;
            4'h7:       s = SEL_STAT_CMD;
            4'hE:       s = SEL_ALT_CTL;
            4'hF:       s = SEL_DRV_RSV;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Selector owned by each slot of the writable register file
    function automatic tf_sel_e tf_slot_sel(input int slot);
        tf_sel_e s;
        case (slot)
            0:       s = SEL_ERR_FEAT;
            1:       s = SEL_SEC_CNT;
            2:       s = SEL_SEC_NUM;
            3:       s = SEL_CYL_LO;
            4:       s = SEL_CYL_HI;
            5:       s = SEL_CARD_HEAD;
            6:       s = SEL_STAT_CMD;
            default: s = SEL_ALT_CTL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ata_tf_addr_decode.sv
module ata_tf_addr_decode
    import ata_tf_pkg::*;
(
    input  logic [3:0] addr,
    input  logic       ce1_n,
    input  logic       ce2_n,
    output acc_t       acc
);

    logic word_data;

    always_comb begin
        word_data = (addr[3:1] == 3'd0) || (addr[3:1] == 3'd4);
        acc.kind  = ACC_NONE;
        acc.lo    = SEL_NONE;
        acc.hi    = SEL_NONE;
        unique case ({ce2_n, ce1_n})
            2'b00: begin
                acc.kind = ACC_WORD;
                if (word_data) begin
                    acc.lo = SEL_DATA_WORD;
                    acc.hi = SEL_DATA_WORD;
                end else begin
                    acc.lo = byte_sel({addr[3:1], 1'b0});
                    acc.hi = byte_sel({addr[3:1], 1'b1});
                end
            end
            2'b10: begin
                acc.kind = ACC_BYTE_LO;
                acc.lo   = byte_sel(addr);
            end
            2'b01: begin
                acc.kind = ACC_BYTE_HI;
                acc.hi   = byte_sel({addr[3:1], 1'b1});
            end
            default: acc.kind = ACC_NONE;
        endcase
    end

endmodule

// File: rtl/ata_tf_byte_ptr.sv
module ata_tf_byte_ptr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step_word,
    input  logic          step_byte,
    input  logic          byte_via_odd,
    output logic          byte_ptr,
    output logic          odd_first,
    output logic [AW-1:0] word_addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_ptr  <= 1'b0;
            odd_first <= 1'b0;
            word_addr <= '0;
        end else if (clear) begin
            byte_ptr  <= 1'b0;
            odd_first <= 1'b0;
            word_addr <= '0;
        end else if (step_word) begin
            byte_ptr  <= 1'b0;
            odd_first <= 1'b0;
            word_addr <= word_addr + 1'b1;
        end else if (step_byte) begin
            if (!byte_ptr) begin
                byte_ptr  <= 1'b1;
                odd_first <= byte_via_odd;
            end else begin
                byte_ptr  <= 1'b0;
                odd_first <= 1'b0;
                word_addr <= word_addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ata_tf_sector_buf.sv
module ata_tf_sector_buf #(
    parameter int WORDS = 16,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata
);

    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we_lo) mem[addr][7:0]  <= wdata[7:0];
        if (we_hi) mem[addr][15:8] <= wdata[15:8];
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/ata_tf_decoder.sv
module ata_tf_decoder
    import ata_tf_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    localparam int AW = $clog2(BUF_WORDS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  addr,
    input  logic        ce1_n,
    input  logic        ce2_n,
    input  logic        iord_n,
    input  logic        iowr_n,
    input  logic [15:0] data_in,
    output logic [15:0] data_out,
    output logic        data_oe_lo,
    output logic        data_oe_hi,
    input  logic [7:0]  err_in,
    input  logic [7:0]  status_in,
    input  logic [7:0]  drv_addr_in,
    output logic [7:0]  features_o,
    output logic [7:0]  dev_ctl_o,
    output logic [7:0]  command_o,
    output logic        cmd_strobe
);

    bus_state_e state, state_nx;
    acc_t       dec_acc, cur_acc;

    logic          commit_rd, commit_wr;
    logic          lo_wr_ok, hi_wr_ok;
    tf_sel_e       act_sel;
    logic          is_data_byte, is_data_word;
    logic          pick_odd;
    logic          cmd_hit;
    logic          byte_ptr, odd_first;
    logic [AW-1:0] word_addr;
    logic [15:0]   buf_rd, buf_wd;
    logic          buf_we_lo, buf_we_hi;
    logic [7:0]    tf_q [NUM_TF];
    logic [7:0]    lane_byte [2];

    ata_tf_addr_decode u_dec (
        .addr  (addr),
        .ce1_n (ce1_n),
        .ce2_n (ce2_n),
        .acc   (dec_acc)
    );

    // State register and latched decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_acc <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) cur_acc <= dec_acc;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (dec_acc.kind != ACC_NONE && !iord_n)      state_nx = ST_READ;
                else if (dec_acc.kind != ACC_NONE && !iowr_n) state_nx = ST_WRITE;
            end
            ST_READ:  if (iord_n) state_nx = ST_IDLE;
            ST_WRITE: if (iowr_n) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs and commit controls
    always_comb begin
        commit_rd  = (state == ST_READ)  && iord_n;
        commit_wr  = (state == ST_WRITE) && iowr_n;
        lo_wr_ok   = commit_wr && (cur_acc.kind == ACC_BYTE_LO || cur_acc.kind == ACC_WORD);
        hi_wr_ok   = commit_wr && (cur_acc.kind == ACC_BYTE_HI || cur_acc.kind == ACC_WORD);
        data_oe_lo = (state == ST_READ) && (cur_acc.kind == ACC_BYTE_LO || cur_acc.kind == ACC_WORD);
        data_oe_hi = (state == ST_READ) && (cur_acc.kind == ACC_BYTE_HI || cur_acc.kind == ACC_WORD);
        act_sel    = (cur_acc.kind == ACC_BYTE_HI) ? cur_acc.hi : cur_acc.lo;
        is_data_byte = (cur_acc.kind == ACC_BYTE_LO || cur_acc.kind == ACC_BYTE_HI)
                       && (act_sel == SEL_DATA_SEQ || act_sel == SEL_DATA_ODD);
        is_data_word = (cur_acc.kind == ACC_WORD) && (cur_acc.lo == SEL_DATA_WORD);
        if (act_sel == SEL_DATA_ODD) pick_odd = 1'b1;
        else                         pick_odd = byte_ptr && !odd_first;
        cmd_hit = (lo_wr_ok && cur_acc.lo == SEL_STAT_CMD)
               || (hi_wr_ok && cur_acc.hi == SEL_STAT_CMD);
        buf_we_lo = commit_wr && (is_data_word || (is_data_byte && !pick_odd));
        buf_we_hi = commit_wr && (is_data_word || (is_data_byte && pick_odd));
        if (is_data_word)                    buf_wd = data_in;
        else if (cur_acc.kind == ACC_BYTE_HI) buf_wd = {data_in[15:8], data_in[15:8]};
        else                                 buf_wd = {data_in[7:0], data_in[7:0]};
        data_out = {data_oe_hi ? lane_byte[1] : 8'h00,
                    data_oe_lo ? lane_byte[0] : 8'h00};
    end

    ata_tf_byte_ptr #(.AW(AW)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (cmd_hit),
        .step_word    ((commit_rd || commit_wr) && is_data_word),
        .step_byte    ((commit_rd || commit_wr) && is_data_byte),
        .byte_via_odd (act_sel == SEL_DATA_ODD),
        .byte_ptr     (byte_ptr),
        .odd_first    (odd_first),
        .word_addr    (word_addr)
    );

    ata_tf_sector_buf #(.WORDS(BUF_WORDS)) u_buf (
        .clk   (clk),
        .we_lo (buf_we_lo),
        .we_hi (buf_we_hi),
        .addr  (word_addr),
        .wdata (buf_wd),
        .rdata (buf_rd)
    );

    // Writable task-file registers, one slot per selector
    for (genvar r = 0; r < NUM_TF; r++) begin : g_tf
        localparam tf_sel_e MY_SEL = tf_slot_sel(r);
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (lo_wr_ok && cur_acc.lo == MY_SEL) q <= data_in[7:0];
            else if (hi_wr_ok && cur_acc.hi == MY_SEL) q <= data_in[15:8];
        end
        assign tf_q[r] = q;
    end

    // Read byte for each lane
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        tf_sel_e    lsel;
        logic [7:0] rbyte;
        always_comb begin
            lsel = (ln == 1) ? cur_acc.hi : cur_acc.lo;
            case (lsel)
                SEL_DATA_SEQ, SEL_DATA_ODD: rbyte = pick_odd ? buf_rd[15:8] : buf_rd[7:0];
                SEL_DATA_WORD: rbyte = buf_rd[8*ln +: 8];
                SEL_ERR_FEAT:  rbyte = err_in;
                SEL_SEC_CNT:   rbyte = tf_q[1];
                SEL_SEC_NUM:   rbyte = tf_q[2];
                SEL_CYL_LO:    rbyte = tf_q[3];
                SEL_CYL_HI:    rbyte = tf_q[4];
                SEL_CARD_HEAD: rbyte = tf_q[5];
                SEL_STAT_CMD,
                SEL_ALT_CTL:   rbyte = status_in;
                SEL_DRV_RSV:   rbyte = drv_addr_in;
                default:       rbyte = 8'h00;
            endcase
        end
        assign lane_byte[ln] = rbyte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_strobe <= 1'b0;
        else        cmd_strobe <= cmd_hit;
    end

    assign features_o = tf_q[0];
    assign command_o  = tf_q[6];
    assign dev_ctl_o  = tf_q[7];

endmodule

// File: rtl/ata_tf_decoder_chk.sv
module ata_tf_decoder_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iord_n,
    input logic          iowr_n,
    input logic          data_oe_lo,
    input logic          data_oe_hi,
    input logic          cmd_strobe,
    input logic          byte_ptr,
    input logic [AW-1:0] word_addr
);

    // R4 / R6: a lane is driven only while a read strobe was seen low
    p_oe_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_lo || data_oe_hi) |-> !$past(iord_n));

    // R10: the command pulse lasts one cycle
    p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    // R10: the position is at word 0, even byte while the pulse is high
    p_cmd_clears_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> (word_addr == '0 && !byte_ptr));

    // R7 / R8: apart from a command clear, the word address only steps by one
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_addr != $past(word_addr) && !cmd_strobe)
            |-> word_addr == AW'($past(word_addr) + 1'b1));

    // R8: the byte pointer moves only after the strobes are released
    p_ptr_trailing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ptr != $past(byte_ptr)) |-> ($past(iord_n) && $past(iowr_n)));

endmodule

bind ata_tf_decoder ata_tf_decoder_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iord_n     (iord_n),
    .iowr_n     (iowr_n),
    .data_oe_lo (data_oe_lo),
    .data_oe_hi (data_oe_hi),
    .cmd_strobe (cmd_strobe),
    .byte_ptr   (byte_ptr),
    .word_addr  (word_addr)
);

// File: tb/ata_tf_decoder_tb.sv
`timescale 1ns/1ps
module ata_tf_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1;
    logic        iord_n = 1'b1, iowr_n = 1'b1;
    logic [15:0] data_in = 16'h0;
    logic [15:0] data_out;
    logic        data_oe_lo, data_oe_hi;
    logic [7:0]  err_in = 8'h81, status_in = 8'h50, drv_addr_in = 8'hE2;
    logic [7:0]  features_o, dev_ctl_o, command_o;
    logic        cmd_strobe;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ata_tf_decoder #(.BUF_WORDS(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .data_in(data_in), .data_out(data_out),
        .data_oe_lo(data_oe_lo), .data_oe_hi(data_oe_hi), .err_in(err_in),
        .status_in(status_in), .drv_addr_in(drv_addr_in), .features_o(features_o),
        .dev_ctl_o(dev_ctl_o), .command_o(command_o), .cmd_strobe(cmd_strobe)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic io_read(input logic [3:0] a, input logic c1, input logic c2,
                           output logic [15:0] d, output logic [1:0] oe);
        @(negedge clk);
        addr = a; ce1_n = c1; ce2_n = c2; iord_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        d = data_out; oe = {data_oe_hi, data_oe_lo};
        iord_n = 1'b1;
        @(negedge clk);
        ce1_n = 1'b1; ce2_n = 1'b1;
    endtask

    task automatic io_write(input logic [3:0] a, input logic c1, input logic c2,
                            input logic [15:0] d, output logic stb);
        @(negedge clk);
        addr = a; ce1_n = c1; ce2_n = c2; data_in = d; iowr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        iowr_n = 1'b1;
        @(negedge clk);
        stb = cmd_strobe;
        ce1_n = 1'b1; ce2_n = 1'b1;
        @(negedge clk);
        chk("R10", "strobe width", {15'h0, cmd_strobe}, 16'h0);
    endtask

    function automatic logic [15:0] wv(input int i);
        return {8'(192 + i), 8'(64 + i)};
    endfunction

    function automatic logic [7:0] tfv(input int off);
        return 8'(16 * off + 5);
    endfunction

    logic [15:0] rd;
    logic [1:0]  oe;
    logic        stb;

    task automatic cmd_reset();
        io_write(4'h7, 1'b0, 1'b1, 16'h00EC, stb);
        chk("R10", "command strobe", {15'h0, stb}, 16'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "oe", {14'h0, data_oe_hi, data_oe_lo}, 16'h0);
        chk("R1", "cmd_strobe", {15'h0, cmd_strobe}, 16'h0);
        chk("R1", "features", {8'h0, features_o}, 16'h0);
        chk("R1", "dev_ctl", {8'h0, dev_ctl_o}, 16'h0);
        chk("R1", "command", {8'h0, command_o}, 16'h0);
        for (int off = 2; off <= 6; off++) begin
            io_read(4'(off), 1'b0, 1'b1, rd, oe);
            chk("R1", "register zero", rd, 16'h0);
        end

        // R3 / R2 byte register sweep
        for (int off = 2; off <= 6; off++) io_write(4'(off), 1'b0, 1'b1, {8'h0, tfv(off)}, stb);
        for (int off = 2; off <= 6; off++) begin
            io_read(4'(off), 1'b0, 1'b1, rd, oe);
            chk("R3", "register readback", rd, {8'h0, tfv(off)});
            chk("R6", "low lane only", {14'h0, oe}, 16'h1);
        end
        io_write(4'h1, 1'b0, 1'b1, 16'h005A, stb);
        chk("R3", "features via 1", {8'h0, features_o}, 16'h005A);
        io_write(4'hD, 1'b0, 1'b1, 16'h00A5, stb);
        chk("R3", "features via D", {8'h0, features_o}, 16'h00A5);
        io_write(4'hE, 1'b0, 1'b1, 16'h003C, stb);
        chk("R3", "device control", {8'h0, dev_ctl_o}, 16'h003C);
        io_write(4'h7, 1'b0, 1'b1, 16'h0020, stb);
        chk("R3", "command", {8'h0, command_o}, 16'h0020);
        chk("R10", "strobe after command", {15'h0, stb}, 16'h1);
        io_read(4'h1, 1'b0, 1'b1, rd, oe); chk("R2", "error at 1", rd, 16'h0081);
        io_read(4'hD, 1'b0, 1'b1, rd, oe); chk("R2", "error at D", rd, 16'h0081);
        io_read(4'h7, 1'b0, 1'b1, rd, oe); chk("R2", "status at 7", rd, 16'h0050);
        io_read(4'hE, 1'b0, 1'b1, rd, oe); chk("R2", "alt status at E", rd, 16'h0050);
        io_read(4'hF, 1'b0, 1'b1, rd, oe); chk("R2", "drive address at F", rd, 16'h00E2);

        // R3 write to F discarded
        io_write(4'hF, 1'b0, 1'b1, 16'h00FF, stb);
        chk("R3", "F leaves features", {8'h0, features_o}, 16'h00A5);
        chk("R3", "F leaves devctl", {8'h0, dev_ctl_o}, 16'h003C);
        chk("R3", "F leaves command", {8'h0, command_o}, 16'h0020);
        chk("R3", "F no strobe", {15'h0, stb}, 16'h0);
        for (int off = 2; off <= 6; off++) begin
            io_read(4'(off), 1'b0, 1'b1, rd, oe);
            chk("R3", "F leaves register", rd, {8'h0, tfv(off)});
        end

        // R4 no card enable
        io_write(4'h2, 1'b1, 1'b1, 16'h0099, stb);
        io_read(4'h2, 1'b0, 1'b1, rd, oe);
        chk("R4", "ignored write", rd, {8'h0, tfv(2)});
        io_read(4'h2, 1'b1, 1'b1, rd, oe);
        chk("R4", "no drive", {14'h0, oe}, 16'h0);
        chk("R4", "data zero", rd, 16'h0);

        // R5 high lane only
        io_read(4'h0, 1'b1, 1'b0, rd, oe);
        chk("R5", "error on high lane", rd, 16'h8100);
        chk("R6", "high lane only", {14'h0, oe}, 16'h2);
        io_read(4'h2, 1'b1, 1'b0, rd, oe);
        chk("R5", "offset 3 on high lane", rd, {tfv(3), 8'h00});
        io_write(4'h0, 1'b1, 1'b0, 16'h7700, stb);
        chk("R5", "features via high lane", {8'h0, features_o}, 16'h0077);

        // R11 word access to register pairs
        io_read(4'h2, 1'b0, 1'b0, rd, oe);
        chk("R11", "word 2/3", rd, {tfv(3), tfv(2)});
        chk("R6", "both lanes", {14'h0, oe}, 16'h3);
        io_write(4'h4, 1'b0, 1'b0, 16'hBEEF, stb);
        io_read(4'h4, 1'b0, 1'b1, rd, oe); chk("R11", "low of word write", rd, 16'h00EF);
        io_read(4'h5, 1'b0, 1'b1, rd, oe); chk("R11", "high of word write", rd, 16'h00BE);

        // R7 word data, A0 ignored, offsets 0/1/8/9
        cmd_reset();
        for (int i = 0; i < 16; i++) begin
            logic [3:0] a;
            a = (i % 4 == 0) ? 4'h0 : (i % 4 == 1) ? 4'h1 : (i % 4 == 2) ? 4'h8 : 4'h9;
            io_write(a, 1'b0, 1'b0, wv(i), stb);
        end
        cmd_reset();
        for (int i = 0; i < 6; i++) begin
            logic [3:0] a;
            a = (i % 4 == 0) ? 4'h9 : (i % 4 == 1) ? 4'h8 : (i % 4 == 2) ? 4'h1 : 4'h0;
            io_read(a, 1'b0, 1'b0, rd, oe);
            chk("R7", "word data", rd, wv(i));
        end

        // R8 sequential bytes at 0 and 8
        cmd_reset();
        for (int j = 0; j < 8; j++) begin
            logic [15:0] w;
            w = wv(j / 2);
            io_read((j < 4) ? 4'h0 : 4'h8, 1'b0, 1'b1, rd, oe);
            chk("R8", "sequential byte", rd, {8'h0, (j % 2 == 1) ? w[15:8] : w[7:0]});
        end

        // R9 alternating 8 then 9
        cmd_reset();
        for (int j = 0; j < 6; j++) begin
            logic [15:0] w;
            w = wv(j / 2);
            io_read((j % 2 == 0) ? 4'h8 : 4'h9, 1'b0, 1'b1, rd, oe);
            chk("R9", "8 then 9", rd, {8'h0, (j % 2 == 1) ? w[15:8] : w[7:0]});
        end

        // R9 order 9 then 8
        cmd_reset();
        for (int j = 0; j < 6; j++) begin
            logic [15:0] w;
            w = wv(j / 2);
            io_read((j % 2 == 0) ? 4'h9 : 4'h8, 1'b0, 1'b1, rd, oe);
            chk("R9", "9 then 8", rd, {8'h0, (j % 2 == 0) ? w[15:8] : w[7:0]});
        end

        // R10 command clears position mid-word
        cmd_reset();
        io_read(4'h0, 1'b0, 1'b1, rd, oe);
        io_read(4'h0, 1'b0, 1'b1, rd, oe);
        io_read(4'h0, 1'b0, 1'b1, rd, oe);
        chk("R10", "third byte before clear", rd, {8'h0, wv(1) & 16'h00FF});
        cmd_reset();
        io_read(4'h0, 1'b0, 1'b1, rd, oe);
        chk("R10", "first byte after clear", rd, {8'h0, wv(0) & 16'h00FF});

        // R4 unselected read does not move the position
        io_read(4'h0, 1'b1, 1'b1, rd, oe);
        io_read(4'h0, 1'b0, 1'b1, rd, oe);
        chk("R4", "position held", rd, {8'h0, wv(0) >> 8});

        // R5 high-lane access at 0 leaves the buffer alone
        cmd_reset();
        io_write(4'h0, 1'b1, 1'b0, 16'h3300, stb);
        io_read(4'h0, 1'b0, 1'b0, rd, oe);
        chk("R5", "buffer untouched", rd, wv(0));

        // R8 / R9 byte writes
        cmd_reset();
        io_write(4'h0, 1'b0, 1'b1, 16'h0011, stb);
        io_write(4'h0, 1'b0, 1'b1, 16'h0022, stb);
        io_write(4'h8, 1'b0, 1'b1, 16'h0033, stb);
        io_write(4'h9, 1'b0, 1'b1, 16'h0044, stb);
        io_write(4'h9, 1'b0, 1'b1, 16'h0066, stb);
        io_write(4'h8, 1'b0, 1'b1, 16'h0055, stb);
        cmd_reset();
        io_read(4'h0, 1'b0, 1'b0, rd, oe); chk("R8", "byte writes word 0", rd, 16'h2211);
        io_read(4'h0, 1'b0, 1'b0, rd, oe); chk("R9", "8/9 writes word 1", rd, 16'h4433);
        io_read(4'h0, 1'b0, 1'b0, rd, oe); chk("R9", "9/8 writes word 2", rd, 16'h6655);
        io_read(4'h0, 1'b0, 1'b0, rd, oe); chk("R7", "word 3 kept", rd, wv(3));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule